// File: doc/BRIEF.md
# Block-Write Control Register Slave

This block is a write-only slave on a two-wire SMBus/I2C bus. It holds a small bank of 8-bit control registers that drive the configuration of a clock generator. SCL and SDA come in from the pads and pass through synchronisers clocked by a faster system clock. The block then recognises START and STOP conditions and compares the first byte with a write address picked by three strap pins. After that it walks through one block-write transaction: a command byte, a byte count and a run of data bytes.

The data bytes land in consecutive registers, beginning at register 0 in every transaction. The master may end the transfer with STOP after any whole byte, and whatever was stored up to that point stays. The only bus output is an open-drain pull-down request for SDA, used to acknowledge each byte the block accepts. The register contents leave the block as one flat vector for the clock logic nearby.

Top module: `smb_blkwr_slave`

## Requirements
- R1: After reset, register 0 holds 0xA1 and registers 1 and 2 hold 0xFF. Register k appears on `regs_o[8k+7:8k]`.
- R2: The strap pins select the expected first byte, which is the 7-bit address followed by R/W = 0. The mapping of `strap_i` values is 0→0xDE, 1→0xDC, 2→0xDA, 3→0xD8, 4→0xD6, 5→0xD4, 6→0xD0, 7→0xD2. A matching first byte is acknowledged.
- R3: A first byte that does not match is not acknowledged, and this includes the matching address with R/W = 1. No later byte is acknowledged or written until the next START.
- R4: The only command byte accepted is 0x00. Any other command is not acknowledged, and the rest of the transfer is ignored.
- R5: Bits are received MSB first. The first data byte goes to register 0, the next to register 1, and so on upward.
- R6: For each accepted byte (address, command, count or data), the block pulls SDA low from the SCL fall that ends the eighth bit until the SCL fall that ends the ninth clock. It releases SDA after that fall.
- R7: A STOP after a complete byte keeps every data byte already received. A data byte cut short by STOP changes no register.
- R8: Data bytes beyond the last register are acknowledged and then discarded. The byte-count value never limits how many registers are written.
- R9: A START seen in the middle of a transfer abandons that transfer and begins address matching again.
- R10: After STOP the SDA pull-down is released, and bytes clocked without a new START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad (wired-AND line) |
| strap_i | input | 3 | Address strap selection |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| regs_o | output | 24 | Register contents, register k at bits 8k+7:8k |

## Verification
The register write and the acknowledge decision for a data byte are made in the same system-clock cycle, on the detected SCL fall that ends the eighth bit. The bench separates the two by sending more data bytes than there are registers, and by using a byte count smaller than the number of bytes sent. Both cases produce an acknowledge while the write is suppressed, or a write that the count does not block. It judges the acknowledge on the line during the ninth SCL high phase, and judges the write by reading the register outputs after STOP.

// File: rtl/smb_blkwr_pkg.sv
package smb_blkwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_DATA,
    ST_SKIP
  } xfer_st_e;

  localparam logic [7:0] BLOCK_CMD = 8'h00;

  // strap code -> 8-bit write address; codes 6/7 break the descending run
  function automatic logic [7:0] strap_to_addr(input logic [2:0] s);
    if (s[2] && s[1]) return {6'b110100, s[0], 1'b0};
    return 8'hDE - {4'b0000, s, 1'b0};
  endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/smb_line_mon.sv
module smb_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // SDA edges only count as bus conditions while SCL stays high
  assign start_o    = scl_s_i && scl_q && sda_q && !sda_s_i;
  assign stop_o     = scl_s_i && scl_q && !sda_q && sda_s_i;
  assign scl_rise_o = scl_s_i && !scl_q;
  assign scl_fall_o = !scl_s_i && scl_q;

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_blkwr_pkg::*;
#(
  parameter int NREG  = 3,
  parameter int PTR_W = $clog2(NREG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             scl_lvl_i,
  input  logic             sda_lvl_i,
  input  logic [7:0]       my_addr_i,
  output logic             ack_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NREG);

  xfer_st_e         st_q;
  logic [3:0]       cnt_q;
  logic [7:0]       sh_q;
  logic             ack_q;
  logic [PTR_W-1:0] ptr_q;

  logic byte_done, ack_done, byte_ok;

  assign byte_done = scl_fall_i && (cnt_q == 4'd8) && (st_q != ST_IDLE);
  assign ack_done  = scl_fall_i && (cnt_q == 4'd9) && (st_q != ST_IDLE);

  always_comb begin
    unique case (st_q)
      ST_ADDR: byte_ok = (sh_q == my_addr_i);
      ST_CMD:  byte_ok = (sh_q == BLOCK_CMD);
      ST_CNT:  byte_ok = 1'b1;
      ST_DATA: byte_ok = 1'b1;
      default: byte_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      ack_q <= 1'b0;
      ptr_q <= '0;
    end else if (start_i) begin
      st_q  <= ST_ADDR;
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (stop_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise_i && cnt_q < 4'd8) begin
        sh_q  <= {sh_q[6:0], sda_lvl_i};
        cnt_q <= cnt_q + 4'd1;
      end else if (byte_done) begin
        cnt_q <= 4'd9;
        ack_q <= byte_ok;
        unique case (st_q)
          ST_ADDR: st_q <= byte_ok ? ST_CMD : ST_SKIP;
          ST_CMD:  st_q <= byte_ok ? ST_CNT : ST_SKIP;
          ST_CNT: begin
            st_q  <= ST_DATA;
            ptr_q <= '0;
          end
          ST_DATA: if (ptr_q < PTR_END) ptr_q <= ptr_q + 1'b1;
          default: st_q <= ST_SKIP;
        endcase
      end else if (ack_done) begin
        cnt_q <= '0;
        ack_q <= 1'b0;
      end
    end
  end

  assign ack_o     = ack_q;
  assign wr_en_o   = byte_done && !start_i && !stop_i && (st_q == ST_DATA) && (ptr_q < PTR_END);
  assign wr_idx_o  = ptr_q;
  assign wr_data_o = sh_q;

  AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> !scl_lvl_i); // R6
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!ack_q && st_q == ST_IDLE)); // R10
  AST_START_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_q == ST_ADDR && cnt_q == 4'd0 && !ack_q)); // R9
  AST_SKIP_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP) |-> !ack_q); // R3

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int              NREG    = 3,
  parameter int              PTR_W   = $clog2(NREG + 1),
  parameter logic [NREG*8-1:0] RST_VAL = 24'hFFFFA1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [7:0]        wr_data_i,
  output logic [NREG*8-1:0] regs_o
);

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [7:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    val_q <= RST_VAL[8*k +: 8];
      else if (wr_en_i && wr_idx_i == PTR_W'(k))      val_q <= wr_data_i;
    end
    assign regs_o[8*k +: 8] = val_q;
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_idx_i) < NREG)); // R8
  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o)); // R7

endmodule

// File: rtl/smb_blkwr_slave.sv
module smb_blkwr_slave
  import smb_blkwr_pkg::*;
#(
  parameter int                NREG    = 3,
  parameter logic [NREG*8-1:0] RST_VAL = 24'hFFFFA1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_pull_o,
  output logic [NREG*8-1:0] regs_o
);

  localparam int PTR_W = $clog2(NREG + 1);

  logic [1:0]       line_s;
  logic             start, stop, rise, fall;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  smb_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (line_s)
  );

  smb_line_mon u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (line_s[1]),
    .sda_s_i    (line_s[0]),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (rise),
    .scl_fall_o (fall)
  );

  smb_xfer_fsm #(.NREG(NREG), .PTR_W(PTR_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .stop_i     (stop),
    .scl_rise_i (rise),
    .scl_fall_i (fall),
    .scl_lvl_i  (line_s[1]),
    .sda_lvl_i  (line_s[0]),
    .my_addr_i  (strap_to_addr(strap_i)),
    .ack_o      (sda_pull_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  smb_reg_bank #(.NREG(NREG), .PTR_W(PTR_W), .RST_VAL(RST_VAL)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .regs_o    (regs_o)
  );

endmodule

// File: tb/smb_blkwr_slave_bench.sv
module smb_blkwr_slave_bench;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  strap = 3'd0;
  logic        sda_pull;
  logic [23:0] regs;
  logic        sda_line;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  assign sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  smb_blkwr_slave u_smb_blkwr_slave (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .sda_pull_o (sda_pull),
    .regs_o     (regs)
  );

  // {strap, first byte, expected ack}
  localparam logic [11:0] VEC [0:11] = '{
    {3'd0, 8'hDE, 1'b1}, {3'd1, 8'hDC, 1'b1}, {3'd2, 8'hDA, 1'b1},
    {3'd3, 8'hD8, 1'b1}, {3'd4, 8'hD6, 1'b1}, {3'd5, 8'hD4, 1'b1},
    {3'd6, 8'hD0, 1'b1}, {3'd7, 8'hD2, 1'b1}, {3'd0, 8'hDC, 1'b0},
    {3'd7, 8'hD0, 1'b0}, {3'd6, 8'hD1, 1'b0}, {3'd3, 8'hD9, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; tick(Q);
      scl = 1'b1;     tick(2*Q);
      scl = 1'b0;     tick(Q);
    end
  endtask

  // byte plus ack slot; checks ack during SCL high and release after the fall
  task automatic xfer(input logic [7:0] b, input logic exp_ack, input string req);
    logic acked;
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    acked = ~sda_line;
    tick(Q);
    scl = 1'b0;   tick(Q);
    check(req, 32'(acked), 32'(exp_ack));
    if (exp_ack) check({req, " release"}, 32'(sda_pull), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(4);
    check("R1 reset regs", 32'(regs), 32'h00FFFFA1);
    check("R1 reset pull", 32'(sda_pull), 32'd0);

    // address table walk, R2 / R3
    for (int k = 0; k < 12; k++) begin
      strap = VEC[k][11:9];
      tick(4);
      bus_start();
      xfer(VEC[k][8:1], VEC[k][0], VEC[k][0] ? "R2 addr match" : "R3 addr reject");
      bus_stop();
    end
    check("R3 regs untouched", 32'(regs), 32'h00FFFFA1);

    strap = 3'd3;
    tick(4);

    // full block write, R5 / R6
    bus_start();
    xfer(8'hD8, 1'b1, "R6 addr");
    xfer(8'h00, 1'b1, "R6 cmd");
    xfer(8'h03, 1'b1, "R6 count");
    xfer(8'h11, 1'b1, "R6 data0");
    xfer(8'h22, 1'b1, "R6 data1");
    xfer(8'h33, 1'b1, "R6 data2");
    bus_stop();
    check("R5 fill from reg0", 32'(regs), 32'h00332211);

    // R/W = 1: nothing accepted after, R3
    bus_start();
    xfer(8'hD9, 1'b0, "R3 read bit");
    xfer(8'h00, 1'b0, "R3 cmd after nack");
    xfer(8'h01, 1'b0, "R3 count after nack");
    xfer(8'h5A, 1'b0, "R3 data after nack");
    bus_stop();
    check("R3 regs after read", 32'(regs), 32'h00332211);

    // bad command, R4
    bus_start();
    xfer(8'hD8, 1'b1, "R4 addr");
    xfer(8'h05, 1'b0, "R4 bad cmd");
    xfer(8'h01, 1'b0, "R4 count ignored");
    xfer(8'h77, 1'b0, "R4 data ignored");
    bus_stop();
    check("R4 regs", 32'(regs), 32'h00332211);

    // count 1, four data bytes, R8
    bus_start();
    xfer(8'hD8, 1'b1, "R8 addr");
    xfer(8'h00, 1'b1, "R8 cmd");
    xfer(8'h01, 1'b1, "R8 count");
    xfer(8'h44, 1'b1, "R8 data0");
    xfer(8'h55, 1'b1, "R8 data1");
    xfer(8'h66, 1'b1, "R8 data2");
    xfer(8'h77, 1'b1, "R8 extra acked");
    bus_stop();
    check("R8 extra discarded", 32'(regs), 32'h00665544);

    // early stop after one byte, then stop mid-byte, R7
    bus_start();
    xfer(8'hD8, 1'b1, "R7 addr");
    xfer(8'h00, 1'b1, "R7 cmd");
    xfer(8'h03, 1'b1, "R7 count");
    xfer(8'h9A, 1'b1, "R7 data0");
    bus_stop();
    check("R7 early stop kept", 32'(regs), 32'h0066559A);
    bus_start();
    xfer(8'hD8, 1'b1, "R7 addr2");
    xfer(8'h00, 1'b1, "R7 cmd2");
    xfer(8'h03, 1'b1, "R7 count2");
    send_bits(8'hF0, 3);
    bus_stop();
    check("R7 partial dropped", 32'(regs), 32'h0066559A);

    // repeated start mid-byte, R9
    bus_start();
    xfer(8'hD8, 1'b1, "R9 addr");
    xfer(8'h00, 1'b1, "R9 cmd");
    xfer(8'h02, 1'b1, "R9 count");
    xfer(8'hAB, 1'b1, "R9 data0");
    send_bits(8'hC3, 4);
    bus_start();
    xfer(8'hD8, 1'b1, "R9 readdress");
    xfer(8'h00, 1'b1, "R9 cmd again");
    xfer(8'h02, 1'b1, "R9 count again");
    xfer(8'hCD, 1'b1, "R9 data restart0");
    xfer(8'hEE, 1'b1, "R9 data restart1");
    bus_stop();
    check("R9 restart from reg0", 32'(regs), 32'h0066EECD);

    // repeated start to a foreign address, R9
    bus_start();
    xfer(8'hD8, 1'b1, "R9 addr b");
    xfer(8'h00, 1'b1, "R9 cmd b");
    send_bits(8'h01, 3);
    bus_start();
    xfer(8'hDE, 1'b0, "R9 foreign addr");
    xfer(8'h00, 1'b0, "R9 cmd dropped");
    xfer(8'h01, 1'b0, "R9 count dropped");
    xfer(8'h12, 1'b0, "R9 data dropped");
    bus_stop();
    check("R9 regs kept", 32'(regs), 32'h0066EECD);

    // bytes without START after STOP, R10
    tick(Q);
    check("R10 pull idle", 32'(sda_pull), 32'd0);
    scl = 1'b0; tick(Q);
    xfer(8'hD8, 1'b0, "R10 no start");
    xfer(8'h00, 1'b0, "R10 no start cmd");
    scl = 1'b1; tick(Q);
    check("R10 regs", 32'(regs), 32'h0066EECD);

    // reset restores defaults, R1
    rst_ni = 1'b0; tick(2);
    rst_ni = 1'b1; tick(4);
    check("R1 reset again", 32'(regs), 32'h00FFFFA1);

    finish_run();
  end

endmodule